// File: doc/BRIEF.md
# Vectored Interrupt Source Router

This block takes six level-sensitive interrupt inputs and steers each of them onto one of six output lines. Every input owns a vector register with three fields: a destination server number, a priority and a source number. The source number picks the output line that the input drives. A priority of all ones masks the input. The router keeps a status bit for each input and a pending bit inside each vector register. The pending bit shows whether the input is both active and unmasked.

Input 0 is special. Its status bit sits in a control register next to a second, software-owned interrupt bit. Input 0 counts as active while either of those two bits is set, so its output line stays high until both have cleared. Inputs 1 to 5 report through a separate read-only status register. A single write port and a single combinational read port reach all registers. The server number and the priority of each input are also exported directly, with the server's two low link-pointer bits dropped, for a downstream presentation controller.

Top module: `isr_router`

## Requirements
- R1: After reset, vector register i reads priority 0xFF (bits 39:32) and source number i (bits 31:29), with server and pending bit zero. The control register (address 6) and the status register (address 7) read zero, and all output lines are low.
- R2: A write to vector address i (0 to 5) stores only server (bits 55:40), priority (39:32) and source number (31:29). Every other bit reads back as zero. The pending bit (bit 24) keeps its value unless the written priority is 0xFF, in which case it is cleared.
- R3: When the level of input i changes, the pending bit takes the new activity of that input AND NOT masked, with masked meaning priority equals 0xFF. While the priority is 0xFF the pending bit is never set.
- R4: One clock edge after an input changes, its status bit follows it. Input 0 appears at control bit 46. Inputs 1, 2, 3, 4 and 5 appear at status bits 36, 35, 34, 33 and 32.
- R5: Output line j is high, one edge after the state that causes it, exactly when some active input has its routing equal to j. Two inputs routed to the same line keep it high while either is active.
- R6: Control bit 47 is written through address 6 (data bit 47). Input 0 is active while control bit 46 or bit 47 is set, so its line stays high and its pending bit stays set after input 0 drops while bit 47 holds.
- R7: A written source number of 6 or 7 is stored and read back, but the input's routing keeps its previous line.
- R8: The server output of input i equals its server field shifted right by 2, and its priority output equals its priority field.
- R9: Writes to the status register (address 7) have no effect. All eight addresses are readable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_in | input | 6 | Level interrupt inputs |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address: 0-5 vectors, 6 control, 7 status |
| wr_data | input | 64 | Write data |
| rd_addr | input | 3 | Read address, same map |
| rd_data | output | 64 | Read data (combinational) |
| line_out | output | 6 | Routed interrupt output lines |
| srv_out | output | 6x14 | Per-input server number, link bits removed |
| prio_out | output | 6x8 | Per-input priority |

## Verification
A stale pending bit or a wrong route shows within one clock at the ports. A misrouted input raises the wrong `line_out` bit on the edge after its level change. A stale pending bit shows in the next read of that vector address. Because of this, the bench compares every output line and the currently addressed register against its reference model on every cycle. Random traffic over inputs, writes and read addresses reaches each register within a few cycles. The shared line of input 0 is the slowest fault to expose, because it needs input 0 to drop while control bit 47 is held. The directed sequences build that case explicitly.

// File: rtl/isr_pkg.sv
package isr_pkg;
   localparam int WORD_W   = 64;
   localparam int SRV_W    = 16;
   localparam int PRIO_W   = 8;
   localparam int SRC_W    = 3;
   localparam int SRV_LSB  = 40;
   localparam int PRIO_LSB = 32;
   localparam int SRC_LSB  = 29;
   localparam int PEND_BIT = 24;
   localparam int AUX_BIT  = 47;
   localparam int ST0_BIT  = 46;
   localparam int STAT_TOP = 37;

   typedef struct packed {
      logic [SRV_W-1:0]  server;
      logic [PRIO_W-1:0] prio;
      logic [SRC_W-1:0]  src;
      logic              pend;
   } vec_t;
endpackage

// File: rtl/isr_vector.sv
module isr_vector
   import isr_pkg::*;
#(
   parameter int IDX  = 0,
   parameter int NSRC = 6
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_hit,
   input  logic [SRV_W-1:0]  wr_server,
   input  logic [PRIO_W-1:0] wr_prio,
   input  logic [SRC_W-1:0]  wr_src,
   input  logic              lvl_event,
   input  logic              act_new,
   output logic [WORD_W-1:0] word,
   output logic [SRV_W-1:0]  server,
   output logic [PRIO_W-1:0] prio,
   output logic [SRC_W-1:0]  route
);
   localparam logic [SRC_W:0] NSRC_L = (SRC_W+1)'(NSRC);

   vec_t              v_q;
   logic [SRC_W-1:0]  route_q;
   logic [PRIO_W-1:0] prio_nx;
   logic              masked_nx;
   logic              src_ok;

   assign prio_nx   = wr_hit ? wr_prio : v_q.prio;
   assign masked_nx = (prio_nx == '1);
   assign src_ok    = ({1'b0, wr_src} < NSRC_L);

   always_ff @(posedge clk) begin
      if (rst) begin
         v_q.server <= '0;
         v_q.prio   <= '1;
         v_q.src    <= SRC_W'(IDX);
         v_q.pend   <= 1'b0;
         route_q    <= SRC_W'(IDX);
      end else begin
         if (wr_hit) begin
            v_q.server <= wr_server;
            v_q.prio   <= wr_prio;
            v_q.src    <= wr_src;
            if (src_ok) route_q <= wr_src;
         end
         if (lvl_event)
            v_q.pend <= act_new && !masked_nx;
         else if (wr_hit && masked_nx)
            v_q.pend <= 1'b0;
      end
   end

   assign word = {8'h00, v_q.server, v_q.prio, v_q.src, 4'h0, v_q.pend, 24'h0};
   assign server = v_q.server;
   assign prio   = v_q.prio;
   assign route  = route_q;

   // R3: a masked source never holds a pending bit
   p_masked_no_pend_r3: assert property (@(posedge clk) disable iff (rst)
      (v_q.prio == '1) |-> !v_q.pend);

   // R7: an unsupported source number leaves routing untouched
   p_bad_src_keeps_route_r7: assert property (@(posedge clk) disable iff (rst)
      (wr_hit && !src_ok) |=> $stable(route_q));
endmodule

// File: rtl/isr_status.sv
module isr_status
   import isr_pkg::*;
#(
   parameter int NSRC = 6
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [NSRC-1:0]   irq_in,
   input  logic              wr_ctrl,
   input  logic              wr_aux,
   output logic [NSRC-1:0]   act,
   output logic [NSRC-1:0]   act_nx,
   output logic [NSRC-1:0]   evt,
   output logic [WORD_W-1:0] ctrl_word,
   output logic [WORD_W-1:0] stat_word
);
   logic [NSRC-1:0] st_q;
   logic            aux_q;
   logic            aux_nx;

   assign aux_nx = wr_ctrl ? wr_aux : aux_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q  <= '0;
         aux_q <= 1'b0;
      end else begin
         st_q  <= irq_in;
         aux_q <= aux_nx;
      end
   end

   assign evt       = irq_in ^ st_q;
   assign act[0]    = st_q[0] | aux_q;
   assign act_nx[0] = irq_in[0] | aux_nx;

   always_comb begin
      ctrl_word = '0;
      ctrl_word[AUX_BIT] = aux_q;
      ctrl_word[ST0_BIT] = st_q[0];
   end

   logic [NSRC-1:0][WORD_W-1:0] stat_part;
   assign stat_part[0] = '0;
   for (genvar i = 1; i < NSRC; i++) begin : g_src
      assign act[i]    = st_q[i];
      assign act_nx[i] = irq_in[i];
      always_comb begin
         stat_part[i] = stat_part[i-1];
         stat_part[i][STAT_TOP-i] = st_q[i];
      end
   end
   assign stat_word = stat_part[NSRC-1];

   // R4: status follows the inputs one edge later
   p_status_tracks_r4: assert property (@(posedge clk) disable iff (rst)
      !rst |=> (st_q == $past(irq_in)));
endmodule

// File: rtl/isr_line_map.sv
module isr_line_map #(
   parameter int NSRC  = 6,
   parameter int SRC_W = 3
) (
   input  logic [NSRC-1:0]            act,
   input  logic [NSRC-1:0][SRC_W-1:0] route,
   output logic [NSRC-1:0]            line
);
   for (genvar j = 0; j < NSRC; j++) begin : g_line
      logic hit;
      always_comb begin
         hit = 1'b0;
         for (int i = 0; i < NSRC; i++)
            if (act[i] && route[i] == SRC_W'(j)) hit = 1'b1;
      end
      assign line[j] = hit;
   end
endmodule

// File: rtl/isr_router.sv
module isr_router
   import isr_pkg::*;
#(
   parameter int NSRC = 6,
   localparam int AW  = $clog2(NSRC + 2)
) (
   input  logic                             clk,
   input  logic                             rst,
   input  logic [NSRC-1:0]                  irq_in,
   input  logic                             wr_en,
   input  logic [AW-1:0]                    wr_addr,
   input  logic [WORD_W-1:0]                wr_data,
   input  logic [AW-1:0]                    rd_addr,
   output logic [WORD_W-1:0]                rd_data,
   output logic [NSRC-1:0]                  line_out,
   output logic [NSRC-1:0][SRV_W-3:0]       srv_out,
   output logic [NSRC-1:0][PRIO_W-1:0]      prio_out
);
   localparam logic [AW-1:0] CTRL_A = AW'(NSRC);
   localparam logic [AW-1:0] STAT_A = AW'(NSRC + 1);

   if (NSRC < 2 || NSRC > 6) begin : g_bad_nsrc
      $error("isr_router: NSRC must lie in 2..6");
   end
   if ((1 << SRC_W) < NSRC) begin : g_bad_srcw
      $error("isr_router: source field too narrow");
   end

   logic [NSRC-1:0]              act, act_nx, evt;
   logic [WORD_W-1:0]            ctrl_word, stat_word;
   logic [NSRC-1:0][WORD_W-1:0]  vec_word;
   logic [NSRC-1:0][SRC_W-1:0]   route;
   logic [NSRC-1:0][SRV_W-1:0]   server;
   logic                         unused_wr_bits;

   assign unused_wr_bits = ^{wr_data[63:56], wr_data[28:0]};

   isr_status #(.NSRC(NSRC)) u_status (
      .clk       (clk),
      .rst       (rst),
      .irq_in    (irq_in),
      .wr_ctrl   (wr_en && wr_addr == CTRL_A),
      .wr_aux    (wr_data[AUX_BIT]),
      .act       (act),
      .act_nx    (act_nx),
      .evt       (evt),
      .ctrl_word (ctrl_word),
      .stat_word (stat_word)
   );

   for (genvar i = 0; i < NSRC; i++) begin : g_vec
      isr_vector #(.IDX(i), .NSRC(NSRC)) u_vec (
         .clk       (clk),
         .rst       (rst),
         .wr_hit    (wr_en && wr_addr == AW'(i)),
         .wr_server (wr_data[SRV_LSB +: SRV_W]),
         .wr_prio   (wr_data[PRIO_LSB +: PRIO_W]),
         .wr_src    (wr_data[SRC_LSB +: SRC_W]),
         .lvl_event (evt[i]),
         .act_new   (act_nx[i]),
         .word      (vec_word[i]),
         .server    (server[i]),
         .prio      (prio_out[i]),
         .route     (route[i])
      );
      assign srv_out[i] = server[i][SRV_W-1:2];
   end

   for (genvar i = 1; i < NSRC; i++) begin : g_chk
      // R3: outside the shared input, pending implies the input is active
      p_pend_live_r3: assert property (@(posedge clk) disable iff (rst)
         vec_word[i][PEND_BIT] |-> act[i]);
   end

   isr_line_map #(.NSRC(NSRC), .SRC_W(SRC_W)) u_lines (
      .act   (act),
      .route (route),
      .line  (line_out)
   );

   always_comb begin
      rd_data = '1;
      if (rd_addr == CTRL_A)
         rd_data = ctrl_word;
      else if (rd_addr == STAT_A)
         rd_data = stat_word;
      else
         for (int i = 0; i < NSRC; i++)
            if (rd_addr == AW'(i)) rd_data = vec_word[i];
   end
endmodule

// File: tb/test_isr_router.sv
`timescale 1ns/1ps
module test_isr_router;
   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic [5:0]        irq_in = '0;
   logic              wr_en = 1'b0;
   logic [2:0]        wr_addr = '0;
   logic [63:0]       wr_data = '0;
   logic [2:0]        rd_addr = '0;
   logic [63:0]       rd_data;
   logic [5:0]        line_out;
   logic [5:0][13:0]  srv_out;
   logic [5:0][7:0]   prio_out;

   int errors = 0;
   int checks = 0;
   bit running = 0;
   bit done = 0;

   always #10 clk = ~clk;

   isr_router i_isr_router (
      .clk(clk), .rst(rst), .irq_in(irq_in), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .line_out(line_out), .srv_out(srv_out), .prio_out(prio_out)
   );

   // reference model
   logic [15:0] m_srv [6];
   logic [7:0]  m_pri [6];
   logic [2:0]  m_src [6];
   logic [2:0]  m_rt  [6];
   logic        m_pend[6];
   logic        m_st  [6];
   logic        m_aux;
   logic        naux, hit, evt, actn;
   logic [7:0]  npri;

   always @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < 6; i++) begin
            m_srv[i] = 0; m_pri[i] = 8'hFF; m_src[i] = 3'(i); m_rt[i] = 3'(i);
            m_pend[i] = 0; m_st[i] = 0;
         end
         m_aux = 0;
      end else begin
         naux = (wr_en && wr_addr == 3'd6) ? wr_data[47] : m_aux;
         for (int i = 0; i < 6; i++) begin
            hit  = wr_en && wr_addr == 3'(i);
            npri = hit ? wr_data[39:32] : m_pri[i];
            evt  = irq_in[i] != m_st[i];
            actn = irq_in[i] || (i == 0 && naux);
            if (evt) m_pend[i] = actn && npri != 8'hFF;
            else if (hit && npri == 8'hFF) m_pend[i] = 0;
            if (hit) begin
               m_srv[i] = wr_data[55:40]; m_pri[i] = npri; m_src[i] = wr_data[31:29];
               if (wr_data[31:29] < 3'd6) m_rt[i] = wr_data[31:29];
            end
            m_st[i] = irq_in[i];
         end
         m_aux = naux;
      end
   end

   function automatic logic [63:0] m_rd(input logic [2:0] a);
      logic [63:0] r;
      r = '0;
      if (a < 3'd6)
         r = {8'h00, m_srv[a], m_pri[a], m_src[a], 4'h0, m_pend[a], 24'h0};
      else if (a == 3'd6) begin
         r[47] = m_aux; r[46] = m_st[0];
      end else
         for (int i = 1; i < 6; i++) r[37-i] = m_st[i];
      return r;
   endfunction

   function automatic logic [5:0] m_lines();
      logic [5:0] l;
      l = '0;
      for (int i = 0; i < 6; i++)
         if (i == 0 ? (m_st[0] || m_aux) : m_st[i]) l[m_rt[i]] = 1'b1;
      return l;
   endfunction

   task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
      end
   endtask

   // every-cycle comparison against the model
   always @(negedge clk) begin
      if (running && !rst) begin
         chk(rd_addr < 3'd6 ? "R3 vector read" : (rd_addr == 3'd6 ? "R6 control read" : "R4 status read"),
             rd_data, m_rd(rd_addr));
         chk("R5 lines", {58'h0, line_out}, {58'h0, m_lines()});
         for (int i = 0; i < 6; i++) begin
            chk("R8 server", {50'h0, srv_out[i]}, {50'h0, m_srv[i][15:2]});
            chk("R8 prio", {56'h0, prio_out[i]}, {56'h0, m_pri[i]});
         end
      end
   end

   task automatic wr(input logic [2:0] a, input logic [63:0] d);
      @(posedge clk); #2 wr_en = 1; wr_addr = a; wr_data = d;
      @(posedge clk); #2 wr_en = 0;
   endtask

   task automatic set_irq(input logic [5:0] v);
      @(posedge clk); #2 irq_in = v;
   endtask

   task automatic rd_chk(input logic [2:0] a, input logic [63:0] exp, input string tag);
      @(posedge clk); #2 rd_addr = a;
      @(negedge clk); chk(tag, rd_data, exp);
   endtask

   task automatic line_chk(input logic [5:0] exp, input string tag);
      @(posedge clk); @(negedge clk);
      chk(tag, {58'h0, line_out}, {58'h0, exp});
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #2 rst = 0; rd_addr = 3'd2;
      running = 1;
      @(negedge clk);
      chk("R1 vector reset", rd_data, 64'h0000_00FF_4000_0000);
      chk("R1 lines reset", {58'h0, line_out}, 64'h0);
      rd_chk(3'd6, 64'h0, "R1 control reset");
      rd_chk(3'd7, 64'h0, "R1 status reset");
      rd_chk(3'd5, 64'h0000_00FF_A000_0000, "R1 vector5 reset");

      // R2 field masking on write
      wr(3'd1, 64'hFFAB_CD10_3FFF_FFFF);
      rd_chk(3'd1, 64'h00AB_CD10_2000_0000, "R2 field mask");
      // R3/R4/R5 assert input 1
      set_irq(6'b000010);
      rd_chk(3'd1, 64'h00AB_CD10_2100_0000, "R3 pending set");
      rd_chk(3'd7, 64'h0000_0010_0000_0000, "R4 status bit36");
      chk("R5 line1", {58'h0, line_out}, 64'h2);
      // R2 pending kept, then cleared by priority 0xFF
      wr(3'd1, 64'h00AB_CD20_2000_0000);
      rd_chk(3'd1, 64'h00AB_CD20_2100_0000, "R2 pending kept");
      wr(3'd1, 64'h00AB_CDFF_2000_0000);
      rd_chk(3'd1, 64'h00AB_CDFF_2000_0000, "R2 pending cleared");
      set_irq(6'b000000);

      // R6 shared input 0
      wr(3'd0, 64'h0000_0005_0000_0000);
      set_irq(6'b000001);
      rd_chk(3'd6, 64'h0000_4000_0000_0000, "R4 control bit46");
      wr(3'd6, 64'h0000_8000_0000_0000);
      set_irq(6'b000000);
      line_chk(6'b000001, "R6 line held by bit47");
      rd_chk(3'd0, 64'h0000_0005_0100_0000, "R6 pending held");
      rd_chk(3'd6, 64'h0000_8000_0000_0000, "R6 control read");
      wr(3'd6, 64'h0);
      line_chk(6'b000000, "R6 line released");

      // R7 unsupported source number
      wr(3'd2, 64'h0000_0003_E000_0000);
      rd_chk(3'd2, 64'h0000_0003_E000_0000, "R7 stored");
      set_irq(6'b000100);
      line_chk(6'b000100, "R7 route kept");
      rd_chk(3'd2, 64'h0000_0003_E100_0000, "R3 pending unmasked");

      // R5 two inputs on one line
      wr(3'd3, 64'h0000_0001_4000_0000);
      set_irq(6'b001100);
      line_chk(6'b000100, "R5 shared line both");
      set_irq(6'b001000);
      line_chk(6'b000100, "R5 shared line one left");

      // R9 status read-only
      wr(3'd7, 64'hFFFF_FFFF_FFFF_FFFF);
      rd_chk(3'd7, 64'h0000_0004_0000_0000, "R9 status write ignored");

      // R8 downstream fields
      wr(3'd4, 64'h0000_1322_8000_0000);
      @(negedge clk);
      chk("R8 server shift", {50'h0, srv_out[4]}, 64'h4);
      chk("R8 prio out", {56'h0, prio_out[4]}, 64'h22);

      // random traffic, model compared every cycle
      for (int n = 0; n < 3000; n++) begin
         @(posedge clk); #2;
         if ($urandom_range(0, 3) == 0) irq_in = 6'($urandom);
         wr_en = ($urandom_range(0, 4) == 0);
         wr_addr = 3'($urandom);
         wr_data = {$urandom, $urandom};
         if ($urandom_range(0, 3) == 0) wr_data[39:32] = 8'hFF;
         rd_addr = 3'($urandom);
      end
      @(posedge clk); #2 wr_en = 0;
      repeat (3) @(posedge clk);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule